// File: doc/BRIEF.md
# Processor Bus Address Decoder

This block connects an 8-bit processor bus to a ROM, three RAMs and two 8-bit switch input ports. The bus carries a 16-bit address, a memory/I-O space select (`io_m`, high for I/O cycles), and active-low read and write strobes. The block turns these into separate memory and I/O strobes and decodes the address into active-low chip selects.

The map is fixed and uses partial decoding. An 8 KB ROM region starts at 0000h and an 8 KB RAM region starts at 4000h. Two 2 KB RAMs are picked by a 3-to-8 decode of A13..A11, enabled by A15 high and A14 low. One switch port sits in I/O space at port F0h. The other is memory-mapped at F0F0h. Behavioural memories and a read-data multiplexer are part of the block, so a bench can check complete reads and writes at the ports.

Top module: `bus_decoder`

## Requirements
- R1: `memr_n` is low exactly when `io_m`=0 and `rd_n`=0. `memw_n` is low exactly when `io_m`=0 and `wr_n`=0. `ior_n` is low exactly when `io_m`=1 and `rd_n`=0. `iow_n` is low exactly when `io_m`=1 and `wr_n`=0.
- R2: In a memory cycle, `cs_rom_n` is low for addresses 0000h–1FFFh and high from 2000h up. A ROM read returns byte A[7:0] XOR {000, A[12:8]}.
- R3: In a memory cycle, `cs_ram0_n` is low exactly when A15..A13 = 010 (4000h–5FFFh). 3FFFh and 6000h do not select it.
- R4: In a memory cycle, `cs_ram1_n` is low for 8000h–87FFh and `cs_ram2_n` is low for 9000h–97FFh. 87FFh/8800h and 97FFh/9800h are the boundaries, and other decoder outputs select nothing.
- R5: `cs_pio_n` is low exactly when A[7:0] = F0h and `ior_n` is low; A15..A8 are ignored. While it is low, `rdata` equals `sw_io`.
- R6: `cs_pmem_n` is low exactly when the full address equals F0F0h and `memr_n` is low. While it is low, `rdata` equals `sw_mem`.
- R7: When no chip select is low together with its matching read strobe, `rdata` is FFh.
- R8: A RAM stores `wdata` on the rising clock edge while `memw_n` and its chip select are both low. Reads return the stored byte combinationally. Each model keeps 2**STORE_AW bytes (256 by default) indexed by the low address bits, so addresses 256 apart alias.
- R9: At most one chip select is low at any time. No ROM or RAM select is low during an I/O cycle.
- R10: Writes to the ROM region, to either switch port, or done as I/O cycles leave every RAM unchanged.
- R11: While `rst_n` is low, no RAM is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for RAM writes |
| rst_n | input | 1 | Active-low reset; blocks RAM writes |
| addr | input | 16 | Bus address |
| io_m | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| wdata | input | 8 | Write data |
| sw_io | input | 8 | Switch inputs of the I/O-mapped port |
| sw_mem | input | 8 | Switch inputs of the memory-mapped port |
| rdata | output | 8 | Read data returned to the processor |
| memr_n | output | 1 | Memory read strobe |
| memw_n | output | 1 | Memory write strobe |
| ior_n | output | 1 | I/O read strobe |
| iow_n | output | 1 | I/O write strobe |
| cs_rom_n | output | 1 | ROM select |
| cs_ram0_n | output | 1 | 8 KB RAM select |
| cs_ram1_n | output | 1 | First 2 KB RAM select |
| cs_ram2_n | output | 1 | Second 2 KB RAM select |
| cs_pio_n | output | 1 | I/O-mapped port enable |
| cs_pmem_n | output | 1 | Memory-mapped port enable |

## Verification
The assertions check on every clock edge that the strobe pairs exclude each other by space, that at most one select is low, that each select is low only for an address and strobe combination its region allows, and that an unselected bus reads FFh. Only the bench scenarios show that the boundary addresses fall on the correct side, that ROM and port data reach `rdata`, that RAM writes land, alias and survive writes to other regions, and that writes during reset are dropped.

// File: rtl/bus_decoder_pkg.sv
package bus_decoder_pkg;
   localparam int SEL_ROM  = 0;
   localparam int SEL_RAM0 = 1;
   localparam int SEL_RAM1 = 2;
   localparam int SEL_RAM2 = 3;
   localparam int SEL_PIO  = 4;
   localparam int SEL_PMEM = 5;
   localparam int NUM_SEL  = 6;
   localparam int NUM_RAM  = 3;

   function automatic logic [7:0] rom_byte(input logic [12:0] a);
      return a[7:0] ^ {3'b000, a[12:8]};
   endfunction
endpackage

// File: rtl/bus_strobes.sv
module bus_strobes (
   input  logic io_m,
   input  logic rd_n,
   input  logic wr_n,
   output logic memr_n,
   output logic memw_n,
   output logic ior_n,
   output logic iow_n
);
   always_comb begin
      memr_n = io_m | rd_n;
      memw_n = io_m | wr_n;
      ior_n  = ~io_m | rd_n;
      iow_n  = ~io_m | wr_n;
   end
endmodule

// File: rtl/region_decode.sv
module region_decode
   import bus_decoder_pkg::*;
#(
   parameter int          AW        = 16,
   parameter logic [7:0]  IO_PORT   = 8'hF0,
   parameter logic [15:0] MEM_PORT  = 16'hF0F0,
   parameter int          RAM1_OUT  = 0,
   parameter int          RAM2_OUT  = 2
) (
   input  logic [AW-1:0]      addr,
   input  logic               io_m,
   input  logic               memr_n,
   input  logic               ior_n,
   output logic [NUM_SEL-1:0] sel_n
);
   localparam int DEC_OUTS = 8;

   logic                mem_cyc;
   logic                dec_en;
   logic [DEC_OUTS-1:0] dec_y;
   logic                rom_hit;
   logic                ram0_hit;
   logic                pio_hit;
   logic                pmem_hit;

   if (AW != 16) begin : g_bad_aw
      $error("region_decode: the map needs a 16-bit address");
   end
   if (RAM1_OUT == RAM2_OUT || RAM1_OUT >= DEC_OUTS || RAM2_OUT >= DEC_OUTS) begin : g_bad_out
      $error("region_decode: decoder outputs must be distinct and below 8");
   end

   assign mem_cyc = ~io_m;
   assign dec_en  = addr[15] & ~addr[14];

   for (genvar k = 0; k < DEC_OUTS; k++) begin : g_dec
      assign dec_y[k] = dec_en && (addr[13:11] == 3'(k));
   end

   assign rom_hit  = (addr[15:13] == 3'b000);
   assign ram0_hit = (addr[15:13] == 3'b010);
   assign pio_hit  = (addr[7:0] == IO_PORT);
   assign pmem_hit = (addr == MEM_PORT);

   always_comb begin
      sel_n           = '1;
      sel_n[SEL_ROM]  = ~(mem_cyc & rom_hit);
      sel_n[SEL_RAM0] = ~(mem_cyc & ram0_hit);
      sel_n[SEL_RAM1] = ~(mem_cyc & dec_y[RAM1_OUT]);
      sel_n[SEL_RAM2] = ~(mem_cyc & dec_y[RAM2_OUT]);
      sel_n[SEL_PIO]  = ~pio_hit | ior_n;
      sel_n[SEL_PMEM] = ~pmem_hit | memr_n;
   end
endmodule

// File: rtl/ram_model.sv
module ram_model #(
   parameter int STORE_AW = 8,
   parameter int DW       = 8
) (
   input  logic                clk,
   input  logic                we,
   input  logic [STORE_AW-1:0] idx,
   input  logic [DW-1:0]       wdata,
   output logic [DW-1:0]       rdata
);
   localparam int DEPTH = 1 << STORE_AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[idx] <= wdata;
   end

   assign rdata = mem[idx];
endmodule

// File: rtl/read_mux.sv
module read_mux
   import bus_decoder_pkg::*;
#(
   parameter int          DW        = 8,
   parameter logic [7:0]  IDLE_DATA = 8'hFF
) (
   input  logic [NUM_SEL-1:0]         sel_n,
   input  logic                       memr_n,
   input  logic [DW-1:0]              rom_data,
   input  logic [NUM_RAM-1:0][DW-1:0] ram_data,
   input  logic [DW-1:0]              sw_io,
   input  logic [DW-1:0]              sw_mem,
   output logic [DW-1:0]              rdata
);
   always_comb begin
      rdata = DW'(IDLE_DATA);
      if (!memr_n && !sel_n[SEL_ROM]) rdata = rom_data;
      for (int i = 0; i < NUM_RAM; i++) begin
         if (!memr_n && !sel_n[SEL_RAM0 + i]) rdata = ram_data[i];
      end
      if (!sel_n[SEL_PIO])  rdata = sw_io;
      if (!sel_n[SEL_PMEM]) rdata = sw_mem;
   end
endmodule

// File: rtl/bus_decoder.sv
module bus_decoder
   import bus_decoder_pkg::*;
#(
   parameter int          AW        = 16,
   parameter int          DW        = 8,
   parameter int          STORE_AW  = 8,
   parameter logic [7:0]  IO_PORT   = 8'hF0,
   parameter logic [15:0] MEM_PORT  = 16'hF0F0,
   parameter logic [7:0]  IDLE_DATA = 8'hFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic          io_m,
   input  logic          rd_n,
   input  logic          wr_n,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] sw_io,
   input  logic [DW-1:0] sw_mem,
   output logic [DW-1:0] rdata,
   output logic          memr_n,
   output logic          memw_n,
   output logic          ior_n,
   output logic          iow_n,
   output logic          cs_rom_n,
   output logic          cs_ram0_n,
   output logic          cs_ram1_n,
   output logic          cs_ram2_n,
   output logic          cs_pio_n,
   output logic          cs_pmem_n
);
   localparam int SMALL_RAM_AW = 11;

   if (DW != 8) begin : g_bad_dw
      $error("bus_decoder: data bus must be 8 bits");
   end
   if (STORE_AW < 1 || STORE_AW > SMALL_RAM_AW) begin : g_bad_store
      $error("bus_decoder: STORE_AW must lie in 1..11");
   end

   logic [NUM_SEL-1:0]         sel_n;
   logic [NUM_RAM-1:0][DW-1:0] ram_q;
   logic [DW-1:0]              rom_q;

   bus_strobes u_strobes (
      .io_m   (io_m),
      .rd_n   (rd_n),
      .wr_n   (wr_n),
      .memr_n (memr_n),
      .memw_n (memw_n),
      .ior_n  (ior_n),
      .iow_n  (iow_n)
   );

   region_decode #(
      .AW       (AW),
      .IO_PORT  (IO_PORT),
      .MEM_PORT (MEM_PORT),
      .RAM1_OUT (0),
      .RAM2_OUT (2)
   ) u_decode (
      .addr   (addr),
      .io_m   (io_m),
      .memr_n (memr_n),
      .ior_n  (ior_n),
      .sel_n  (sel_n)
   );

   assign rom_q = rom_byte(addr[12:0]);

   for (genvar i = 0; i < NUM_RAM; i++) begin : g_ram
      logic we;
      assign we = rst_n & ~memw_n & ~sel_n[SEL_RAM0 + i];
      ram_model #(
         .STORE_AW (STORE_AW),
         .DW       (DW)
      ) u_ram (
         .clk   (clk),
         .we    (we),
         .idx   (addr[STORE_AW-1:0]),
         .wdata (wdata),
         .rdata (ram_q[i])
      );
   end

   read_mux #(
      .DW        (DW),
      .IDLE_DATA (IDLE_DATA)
   ) u_mux (
      .sel_n    (sel_n),
      .memr_n   (memr_n),
      .rom_data (rom_q),
      .ram_data (ram_q),
      .sw_io    (sw_io),
      .sw_mem   (sw_mem),
      .rdata    (rdata)
   );

   assign cs_rom_n  = sel_n[SEL_ROM];
   assign cs_ram0_n = sel_n[SEL_RAM0];
   assign cs_ram1_n = sel_n[SEL_RAM1];
   assign cs_ram2_n = sel_n[SEL_RAM2];
   assign cs_pio_n  = sel_n[SEL_PIO];
   assign cs_pmem_n = sel_n[SEL_PMEM];
endmodule

// File: rtl/bus_decoder_chk.sv
module bus_decoder_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [15:0] addr,
   input logic        io_m,
   input logic        rd_n,
   input logic        wr_n,
   input logic [7:0]  rdata,
   input logic        memr_n,
   input logic        memw_n,
   input logic        ior_n,
   input logic        iow_n,
   input logic        cs_rom_n,
   input logic        cs_ram0_n,
   input logic        cs_ram1_n,
   input logic        cs_ram2_n,
   input logic        cs_pio_n,
   input logic        cs_pmem_n
);
   logic [5:0] cs_vec;
   assign cs_vec = {cs_pmem_n, cs_pio_n, cs_ram2_n, cs_ram1_n, cs_ram0_n, cs_rom_n};

   p_mem_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      io_m |-> (memr_n && memw_n));
   p_io_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !io_m |-> (ior_n && iow_n));
   p_iow_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !iow_n |-> (io_m && !wr_n));
   p_rom_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_rom_n |-> (!io_m && addr < 16'h2000));
   p_ram0_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_ram0_n |-> (!io_m && addr >= 16'h4000 && addr < 16'h6000));
   p_ram1_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_ram1_n |-> (!io_m && addr >= 16'h8000 && addr < 16'h8800));
   p_ram2_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_ram2_n |-> (!io_m && addr >= 16'h9000 && addr < 16'h9800));
   p_pio_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_pio_n |-> (io_m && !rd_n && addr[7:0] == 8'hF0));
   p_pmem_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_pmem_n |-> (!io_m && !rd_n && addr == 16'hF0F0));
   p_idle_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (&cs_vec) |-> (rdata == 8'hFF));
   p_one_select_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~cs_vec) <= 1);
endmodule

bind bus_decoder bus_decoder_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .addr      (addr),
   .io_m      (io_m),
   .rd_n      (rd_n),
   .wr_n      (wr_n),
   .rdata     (rdata),
   .memr_n    (memr_n),
   .memw_n    (memw_n),
   .ior_n     (ior_n),
   .iow_n     (iow_n),
   .cs_rom_n  (cs_rom_n),
   .cs_ram0_n (cs_ram0_n),
   .cs_ram1_n (cs_ram1_n),
   .cs_ram2_n (cs_ram2_n),
   .cs_pio_n  (cs_pio_n),
   .cs_pmem_n (cs_pmem_n)
);

// File: tb/tb_bus_decoder.sv
module tb_bus_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = 16'h0000;
   logic        io_m = 1'b0;
   logic        rd_n = 1'b1;
   logic        wr_n = 1'b1;
   logic [7:0]  wdata = 8'h00;
   logic [7:0]  sw_io = 8'h5A;
   logic [7:0]  sw_mem = 8'hA7;
   logic [7:0]  rdata;
   logic        memr_n, memw_n, ior_n, iow_n;
   logic        cs_rom_n, cs_ram0_n, cs_ram1_n, cs_ram2_n, cs_pio_n, cs_pmem_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   localparam logic [5:0] NONE = 6'b111111;
   localparam logic [5:0] ROM  = 6'b111110;
   localparam logic [5:0] RAM0 = 6'b111101;
   localparam logic [5:0] RAM1 = 6'b111011;
   localparam logic [5:0] RAM2 = 6'b110111;
   localparam logic [5:0] PIO  = 6'b101111;
   localparam logic [5:0] PMEM = 6'b011111;

   always #4 clk = ~clk;

   bus_decoder dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n),
      .wdata(wdata), .sw_io(sw_io), .sw_mem(sw_mem), .rdata(rdata),
      .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n),
      .cs_rom_n(cs_rom_n), .cs_ram0_n(cs_ram0_n), .cs_ram1_n(cs_ram1_n),
      .cs_ram2_n(cs_ram2_n), .cs_pio_n(cs_pio_n), .cs_pmem_n(cs_pmem_n)
   );

   function automatic logic [5:0] cs_now();
      return {cs_pmem_n, cs_pio_n, cs_ram2_n, cs_ram1_n, cs_ram0_n, cs_rom_n};
   endfunction

   function automatic logic [7:0] rom_exp(input logic [15:0] a);
      return a[7:0] ^ {3'b000, a[12:8]};
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic iom, input logic [15:0] a, input logic r,
                        input logic w, input logic [7:0] d);
      @(negedge clk);
      io_m = iom; addr = a; rd_n = r; wr_n = w; wdata = d;
      #1;
   endtask

   task automatic mem_write(input logic [15:0] a, input logic [7:0] d);
      drive(1'b0, a, 1'b1, 1'b0, d);
      drive(1'b0, a, 1'b1, 1'b1, d);
   endtask

   task automatic mem_read(input string tag, input logic [15:0] a,
                           input logic [5:0] cs_exp, input logic [7:0] d_exp);
      drive(1'b0, a, 1'b0, 1'b1, 8'h00);
      check({tag, " select"}, {10'h0, cs_now()}, {10'h0, cs_exp});
      check({tag, " data"}, {8'h0, rdata}, {8'h0, d_exp});
   endtask

   task automatic t_reset_state();
      check("R1 reset strobes", {12'h0, memr_n, memw_n, ior_n, iow_n}, 16'h000F);
      check("R7 reset idle data", {8'h0, rdata}, 16'h00FF);
   endtask

   task automatic t_strobes();
      drive(1'b0, 16'h2000, 1'b0, 1'b1, 8'h00);
      check("R1 mem read", {12'h0, memr_n, memw_n, ior_n, iow_n}, 16'h0007);
      drive(1'b0, 16'h2000, 1'b1, 1'b0, 8'h00);
      check("R1 mem write", {12'h0, memr_n, memw_n, ior_n, iow_n}, 16'h000B);
      drive(1'b1, 16'h2000, 1'b0, 1'b1, 8'h00);
      check("R1 io read", {12'h0, memr_n, memw_n, ior_n, iow_n}, 16'h000D);
      drive(1'b1, 16'h2000, 1'b1, 1'b0, 8'h00);
      check("R1 io write", {12'h0, memr_n, memw_n, ior_n, iow_n}, 16'h000E);
      drive(1'b1, 16'h2000, 1'b1, 1'b1, 8'h00);
   endtask

   task automatic t_rom();
      mem_read("R2 rom 0000", 16'h0000, ROM, rom_exp(16'h0000));
      mem_read("R2 rom 1234", 16'h1234, ROM, rom_exp(16'h1234));
      mem_read("R2 rom 1FFF", 16'h1FFF, ROM, rom_exp(16'h1FFF));
      mem_read("R2 above 2000", 16'h2000, NONE, 8'hFF);
      drive(1'b1, 16'h0005, 1'b0, 1'b1, 8'h00);
      check("R9 no rom in io cycle", {10'h0, cs_now()}, {10'h0, NONE});
   endtask

   task automatic t_ram0();
      mem_write(16'h4000, 8'h3C);
      mem_write(16'h5FFF, 8'hC3);
      mem_read("R3 ram0 4000", 16'h4000, RAM0, 8'h3C);
      mem_read("R3 ram0 5FFF", 16'h5FFF, RAM0, 8'hC3);
      mem_read("R3 below 3FFF", 16'h3FFF, NONE, 8'hFF);
      mem_read("R3 above 6000", 16'h6000, NONE, 8'hFF);
      mem_read("R8 alias 40FF", 16'h40FF, RAM0, 8'hC3);
   endtask

   task automatic t_ram_small();
      mem_write(16'h8000, 8'h11);
      mem_write(16'h87FF, 8'h22);
      mem_write(16'h9000, 8'h33);
      mem_write(16'h97FF, 8'h44);
      mem_read("R4 ram1 8000", 16'h8000, RAM1, 8'h11);
      mem_read("R4 ram1 87FF", 16'h87FF, RAM1, 8'h22);
      mem_read("R4 ram2 9000", 16'h9000, RAM2, 8'h33);
      mem_read("R4 ram2 97FF", 16'h97FF, RAM2, 8'h44);
      mem_read("R4 gap 8800", 16'h8800, NONE, 8'hFF);
      mem_read("R4 gap 9800", 16'h9800, NONE, 8'hFF);
      mem_read("R4 unused A000", 16'hA000, NONE, 8'hFF);
      mem_read("R4 A14 high C000", 16'hC000, NONE, 8'hFF);
   endtask

   task automatic t_io_port();
      drive(1'b1, 16'hF0F0, 1'b0, 1'b1, 8'h00);
      check("R5 port F0F0 select", {10'h0, cs_now()}, {10'h0, PIO});
      check("R5 port F0F0 data", {8'h0, rdata}, 16'h005A);
      sw_io = 8'h81;
      drive(1'b1, 16'h00F0, 1'b0, 1'b1, 8'h00);
      check("R5 upper byte ignored", {10'h0, cs_now()}, {10'h0, PIO});
      check("R5 new switch data", {8'h0, rdata}, 16'h0081);
      drive(1'b1, 16'hF1F1, 1'b0, 1'b1, 8'h00);
      check("R5 other port", {8'h0, rdata}, 16'h00FF);
      drive(1'b1, 16'hF0F0, 1'b1, 1'b1, 8'h00);
      check("R5 no strobe", {10'h0, cs_now()}, {10'h0, NONE});
   endtask

   task automatic t_mem_port();
      mem_read("R6 mem port F0F0", 16'hF0F0, PMEM, 8'hA7);
      mem_read("R6 mem port F0F1", 16'hF0F1, NONE, 8'hFF);
      drive(1'b0, 16'hF0F0, 1'b1, 1'b1, 8'h00);
      check("R6 no read strobe", {10'h0, cs_now()}, {10'h0, NONE});
      check("R7 unread data", {8'h0, rdata}, 16'h00FF);
      drive(1'b0, 16'h4000, 1'b1, 1'b1, 8'h00);
      check("R7 ram0 selected but not read", {8'h0, rdata}, 16'h00FF);
   endtask

   task automatic t_ignored_writes();
      mem_write(16'h0010, 8'h00);
      mem_read("R10 rom after write", 16'h0010, ROM, rom_exp(16'h0010));
      mem_write(16'hF0F0, 8'h00);
      mem_read("R10 mem port after write", 16'hF0F0, PMEM, 8'hA7);
      drive(1'b1, 16'h0000, 1'b1, 1'b0, 8'hEE);
      drive(1'b1, 16'h0000, 1'b1, 1'b1, 8'hEE);
      mem_read("R10 ram0 after io write", 16'h4000, RAM0, 8'h3C);
      drive(1'b1, 16'h8000, 1'b1, 1'b0, 8'hEE);
      drive(1'b1, 16'h8000, 1'b1, 1'b1, 8'hEE);
      mem_read("R10 ram1 after io write", 16'h8000, RAM1, 8'h11);
      mem_write(16'h0000, 8'h55);
      mem_read("R10 ram1 after rom write", 16'h8000, RAM1, 8'h11);
   endtask

   task automatic t_reset_write();
      @(negedge clk);
      rst_n = 1'b0;
      mem_write(16'h8000, 8'h99);
      @(negedge clk);
      rst_n = 1'b1;
      mem_read("R11 write during reset dropped", 16'h8000, RAM1, 8'h11);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      t_reset_state();
      rst_n = 1'b1;
      t_strobes();
      t_rom();
      t_ram0();
      t_ram_small();
      t_io_port();
      t_mem_port();
      t_ignored_writes();
      t_reset_write();
      drive(1'b0, 16'h2000, 1'b1, 1'b1, 8'h00);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule